// File: doc/BRIEF.md
# Destination Ring Receive Writer

This block is the receiving half of a memory copy channel. Software owns a power-of-two ring of receive descriptors. It hands the engine empty buffers by posting a buffer address, which advances the ring's write index. The engine owns the read index. Each incoming packet is a byte stream closed by an end-of-packet marker, and it may be a gathered group of source fragments. The whole packet lands in the buffer at the current read index. The engine then writes one completion word back into that descriptor: the nonzero byte count, the byte-swap request, an overflow mark and the transfer-id metadata. Only after that write does it advance the read index and pulse a completion event.

Software learns that a descriptor is done when it reads a nonzero length, because a freshly posted descriptor always has a length of zero. The ring always keeps one slot empty, so a full ring can be told apart from an empty one. When no posted buffer is left, the input stalls. When a packet is longer than a buffer, its tail is dropped and the overflow mark is set.

Top module: `dst_ring_rx`

## Requirements
- R1: After reset both indices are 0, post_ready_o is 1, and in_ready_o, done_o and mem_we_o are 0.
- R2: A post is taken only while ((rd_idx - 1 - wr_idx) mod ENTRIES) is nonzero, so at most ENTRIES-1 buffers are outstanding. A post offered while post_ready_o is 0 leaves wr_idx_o unchanged.
- R3: Both indices count modulo ENTRIES and wrap from ENTRIES-1 to 0.
- R4: in_ready_o is 0 whenever rd_idx_o equals wr_idx_o (no posted buffer). It is also 0 during the two completion cycles that follow a packet.
- R5: Byte k of a packet, for k < MAX_LEN, is written in its accept cycle with mem_desc_o=0, mem_addr_o = buffer address + k and mem_data_o = {24'b0, byte}.
- R6: In the cycle after the last byte is accepted, one descriptor write goes out with mem_desc_o=1 and mem_addr_o = desc_base_i + 8*rd_idx + 4. Its data has the length in bits [15:0], the swap flag in bit 16, the overflow flag in bit 17, zeros in bits [19:18] and the metadata in bits [31:20]. The length is never zero.
- R7: done_o pulses for one cycle in the cycle after the descriptor write, and rd_idx_o increments at the end of that cycle. rd_idx_o never changes at any other time.
- R8: Bytes with in_last_i=0 never cause a completion; each packet, however many fragments it gathers, yields exactly one completion.
- R9: Bytes past MAX_LEN are not written. The length is then reported as MAX_LEN with the overflow flag set; a packet of exactly MAX_LEN bytes has the flag clear.
- R10: The metadata and swap flag reported are those presented with the last byte of the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_base_i | input | AW | Byte address of descriptor 0 |
| post_valid_i | input | 1 | Software posts a buffer |
| post_addr_i | input | AW | Address of the posted buffer |
| post_ready_o | output | 1 | Ring has a free slot for a post |
| wr_idx_o | output | IW | Software write index |
| rd_idx_o | output | IW | Engine read index |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Last byte of packet |
| in_meta_i | input | MW | Transfer-id metadata |
| in_swap_i | input | 1 | Byte-swap request |
| mem_we_o | output | 1 | Memory write strobe |
| mem_desc_o | output | 1 | Write targets a descriptor (1) or payload (0) |
| mem_addr_o | output | AW | Memory write byte address |
| mem_data_o | output | 32 | Memory write data |
| done_o | output | 1 | Completion event |

## Verification
The hardest state to reach is an input stall: a packet must already be waiting when the read index has caught up with the write index. The bench first uses up every posted buffer, then offers a packet. It holds the packet for several cycles and checks that nothing is taken and nothing is written. Only then does it post the buffer that brings the write index around its wrap. Packets of exactly MAX_LEN bytes, one byte past it, and a single byte cover the edges of truncation.

// File: rtl/dst_rx_pkg.sv
package dst_rx_pkg;
  typedef enum logic [1:0] {ST_RECV, ST_DESC, ST_ADV} rx_state_e;
  localparam int FLAG_SWAP_BIT = 16;
  localparam int FLAG_OVF_BIT  = 17;
  localparam int META_LSB      = 20;
endpackage

// File: rtl/dst_ring_idx.sv
module dst_ring_idx #(
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          post_i,
  input  logic          adv_i,
  output logic [IW-1:0] wr_idx_o,
  output logic [IW-1:0] rd_idx_o,
  output logic          space_o,
  output logic          avail_o
);
  logic [IW-1:0] wr_q, rd_q, gap;

  // one slot always left empty
  assign gap      = rd_q - IW'(1) - wr_q;
  assign space_o  = gap != '0;
  assign avail_o  = rd_q != wr_q;
  assign wr_idx_o = wr_q;
  assign rd_idx_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (post_i && space_o) wr_q <= wr_q + IW'(1);
      if (adv_i)             rd_q <= rd_q + IW'(1);
    end
  end
endmodule

// File: rtl/dst_rx_ctrl.sv
module dst_rx_ctrl
  import dst_rx_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MW      = 12,
  parameter int MAX_LEN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          avail_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic [AW-1:0] desc_addr_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [7:0]    in_data_i,
  input  logic          in_last_i,
  input  logic [MW-1:0] in_meta_i,
  input  logic          in_swap_i,
  output logic          mem_we_o,
  output logic          mem_desc_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_data_o,
  output logic          adv_o
);
  localparam int CW = $clog2(MAX_LEN + 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q, swap_q;
  logic [MW-1:0] meta_q;
  logic          fire, room;
  logic [31:0]   desc_word;

  assign in_ready_o = (state_q == ST_RECV) && avail_i;
  assign fire       = in_valid_i && in_ready_o;
  assign room       = cnt_q < CW'(MAX_LEN);
  assign adv_o      = state_q == ST_ADV;

  always_comb begin
    desc_word                   = '0;
    desc_word[15:0]             = 16'(cnt_q);
    desc_word[FLAG_SWAP_BIT]    = swap_q;
    desc_word[FLAG_OVF_BIT]     = ovf_q;
    desc_word[META_LSB +: MW]   = meta_q;
  end

  always_comb begin
    mem_we_o   = 1'b0;
    mem_desc_o = 1'b0;
    mem_addr_o = buf_addr_i + AW'(cnt_q);
    mem_data_o = {24'b0, in_data_i};
    case (state_q)
      ST_RECV: mem_we_o = fire && room;
      ST_DESC: begin
        mem_we_o   = 1'b1;
        mem_desc_o = 1'b1;
        mem_addr_o = desc_addr_i;
        mem_data_o = desc_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RECV;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      swap_q  <= 1'b0;
      meta_q  <= '0;
    end else begin
      case (state_q)
        ST_RECV: if (fire) begin
          if (room) cnt_q <= cnt_q + CW'(1);
          else      ovf_q <= 1'b1;
          if (in_last_i) begin
            meta_q  <= in_meta_i;
            swap_q  <= in_swap_i;
            state_q <= ST_DESC;
          end
        end
        ST_DESC: state_q <= ST_ADV;
        default: begin
          state_q <= ST_RECV;
          cnt_q   <= '0;
          ovf_q   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dst_ring_rx.sv
module dst_ring_rx #(
  parameter int AW        = 32,
  parameter int MW        = 12,
  parameter int RING_LOG2 = 3,
  parameter int MAX_LEN   = 16,
  localparam int IW       = RING_LOG2,
  localparam int ENTRIES  = 1 << RING_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] desc_base_i,
  input  logic          post_valid_i,
  input  logic [AW-1:0] post_addr_i,
  output logic          post_ready_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [IW-1:0] rd_idx_o,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [7:0]    in_data_i,
  input  logic          in_last_i,
  input  logic [MW-1:0] in_meta_i,
  input  logic          in_swap_i,
  output logic          mem_we_o,
  output logic          mem_desc_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_data_o,
  output logic          done_o
);
  logic [AW-1:0] buf_tbl [ENTRIES];
  logic          space, avail, adv;
  logic [AW-1:0] desc_addr;

  assign post_ready_o = space;
  assign done_o       = adv;
  // 8-byte descriptors, completion word at offset 4
  assign desc_addr    = desc_base_i + (AW'(rd_idx_o) << 3) + AW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) buf_tbl[i] <= '0;
    end else if (post_valid_i && space) begin
      buf_tbl[wr_idx_o] <= post_addr_i;
    end
  end

  dst_ring_idx #(.IW(IW)) u_idx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .post_i   (post_valid_i),
    .adv_i    (adv),
    .wr_idx_o (wr_idx_o),
    .rd_idx_o (rd_idx_o),
    .space_o  (space),
    .avail_o  (avail)
  );

  dst_rx_ctrl #(.AW(AW), .MW(MW), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .avail_i     (avail),
    .buf_addr_i  (buf_tbl[rd_idx_o]),
    .desc_addr_i (desc_addr),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .in_last_i   (in_last_i),
    .in_meta_i   (in_meta_i),
    .in_swap_i   (in_swap_i),
    .mem_we_o    (mem_we_o),
    .mem_desc_o  (mem_desc_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .adv_o       (adv)
  );
endmodule

// File: rtl/dst_ring_rx_chk.sv
module dst_ring_rx_chk #(
  parameter int IW      = 3,
  parameter int MAX_LEN = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          post_valid_i,
  input logic          post_ready_o,
  input logic [IW-1:0] wr_idx_o,
  input logic [IW-1:0] rd_idx_o,
  input logic          in_ready_o,
  input logic          mem_we_o,
  input logic          mem_desc_o,
  input logic [31:0]   mem_data_o,
  input logic          done_o
);
  p_post_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_valid_i && !post_ready_o |=> wr_idx_o == $past(wr_idx_o));

  p_full_slot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !post_ready_o |-> IW'(wr_idx_o + IW'(1)) == rd_idx_o);

  p_no_buf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> rd_idx_o != wr_idx_o);

  p_desc_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_we_o && mem_desc_o));

  p_adv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> rd_idx_o == IW'($past(rd_idx_o) + IW'(1)));

  p_rd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(rd_idx_o));

  p_len_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_desc_o |-> mem_data_o[15:0] != 16'd0 && mem_data_o[15:0] <= 16'(MAX_LEN));

  p_ovf_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_desc_o && mem_data_o[17] |-> mem_data_o[15:0] == 16'(MAX_LEN));
endmodule

bind dst_ring_rx dst_ring_rx_chk #(.IW(IW), .MAX_LEN(MAX_LEN)) u_chk (.*);

// File: tb/tb_dst_ring_rx.sv
module tb_dst_ring_rx;
  localparam int AW = 32, MW = 12, RL = 3, ML = 16, IW = RL;
  localparam logic [AW-1:0] DBASE = 32'h0000_1000;

  typedef struct packed {
    logic          desc;
    logic [AW-1:0] addr;
    logic [31:0]   data;
  } wr_t;

  logic clk = 0, rst_n = 0;
  logic          post_valid = 0;
  logic [AW-1:0] post_addr = '0;
  logic          post_ready;
  logic [IW-1:0] wr_idx, rd_idx;
  logic          in_valid = 0, in_ready, in_last = 0, in_swap = 0;
  logic [7:0]    in_data = '0;
  logic [MW-1:0] in_meta = '0;
  logic          mem_we, mem_desc, done;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_data;

  int checks = 0, errors = 0, done_cnt = 0, pkts = 0;
  logic [IW-1:0] rd_m = '0;
  logic [AW-1:0] buf_q[$];
  wr_t exp_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  dst_ring_rx #(.AW(AW), .MW(MW), .RING_LOG2(RL), .MAX_LEN(ML)) dut (
    .clk_i(clk), .rst_ni(rst_n), .desc_base_i(DBASE),
    .post_valid_i(post_valid), .post_addr_i(post_addr), .post_ready_o(post_ready),
    .wr_idx_o(wr_idx), .rd_idx_o(rd_idx),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_last_i(in_last), .in_meta_i(in_meta), .in_swap_i(in_swap),
    .mem_we_o(mem_we), .mem_desc_o(mem_desc), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes and counts completions
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && done) done_cnt++;
      if (rst_n && mem_we) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5/R6 unexpected write", mem_addr, 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          if (e.desc) begin
            chk(mem_desc == 1'b1 && mem_addr == e.addr, "R6 desc addr", mem_addr, e.addr);
            chk(mem_data == e.data, "R6/R9/R10 desc word", mem_data, e.data);
          end else begin
            chk(mem_desc == 1'b0 && mem_addr == e.addr, "R5 payload addr", mem_addr, e.addr);
            chk(mem_data == e.data, "R5 payload data", mem_data, e.data);
          end
        end
      end
    end
  end

  task automatic post(input logic [AW-1:0] a);
    @(negedge clk);
    post_valid = 1; post_addr = a;
    #1;
    if (post_ready) buf_q.push_back(a);
    @(posedge clk); #1;
    post_valid = 0;
  endtask

  task automatic send_pkt(input int n, input logic [MW-1:0] meta, input logic swp, input logic [7:0] b0);
    logic [AW-1:0] ba;
    int d0;
    wr_t e;
    d0 = done_cnt;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = b0 + 8'(k); in_last = (k == n-1);
      in_meta = (k == n-1) ? meta : ~meta;
      in_swap = (k == n-1) ? swp : ~swp;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      if (k == 0) ba = buf_q.pop_front();
      if (k == n-1 && n > 1) chk(done_cnt == d0, "R8 no completion mid-packet", done_cnt, d0);
      if (k < ML) begin
        e.desc = 0; e.addr = ba + AW'(k); e.data = {24'b0, b0 + 8'(k)};
        exp_q.push_back(e);
      end
      if (k == n-1) begin
        e.desc = 1;
        e.addr = DBASE + (AW'(rd_m) << 3) + 4;
        e.data = '0;
        e.data[15:0]  = 16'((n > ML) ? ML : n);
        e.data[16]    = swp;
        e.data[17]    = (n > ML);
        e.data[31:20] = meta;
        exp_q.push_back(e);
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    rd_m = rd_m + IW'(1);
    pkts++;
    repeat (3) @(negedge clk);
    #2;
    chk(rd_idx == rd_m, "R7/R3 read index after packet", 32'(rd_idx), 32'(rd_m));
    chk(done_cnt == d0 + 1, "R8 single completion", done_cnt, d0 + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rd_idx == 0 && wr_idx == 0, "R1 indices", {wr_idx, rd_idx}, 0);
    chk(post_ready == 1, "R1 post_ready", post_ready, 1);
    chk(in_ready == 0 && done == 0 && mem_we == 0, "R1 outputs idle", {in_ready, done, mem_we}, 0);
    rst_n = 1;

    for (int i = 0; i < 7; i++) post(32'h8000 + 32'(i) * 32'h100);
    #1;
    chk(wr_idx == 7, "R2 seven posted", 32'(wr_idx), 7);
    chk(post_ready == 0, "R2 ring full", post_ready, 0);
    post(32'hDEAD_0000);
    #1;
    chk(wr_idx == 7, "R2 post ignored when full", 32'(wr_idx), 7);
    chk(buf_q.size() == 7, "R2 rejected post", buf_q.size(), 7);

    send_pkt(5, 12'h012, 1'b0, 8'h10);
    chk(post_ready == 1, "R2 slot freed", post_ready, 1);
    send_pkt(9, 12'hABC, 1'b1, 8'h40);   // gathered, R10 last-beat fields
    send_pkt(20, 12'h005, 1'b1, 8'h80);  // R9 truncated
    send_pkt(16, 12'h7F0, 1'b0, 8'hA0);  // R9 exact boundary
    send_pkt(17, 12'h001, 1'b0, 8'hC0);  // R9 one past
    send_pkt(1, 12'hFFF, 1'b1, 8'h01);
    send_pkt(1, 12'h333, 1'b0, 8'h02);

    #1;
    chk(in_ready == 0 && rd_idx == wr_idx, "R4 no buffer stall", in_ready, 0);
    fork
      send_pkt(3, 12'h456, 1'b0, 8'h60);
      begin
        repeat (5) @(negedge clk);
        #1;
        chk(in_ready == 0, "R4 held off while empty", in_ready, 0);
        chk(mem_we == 0, "R4 no write while stalled", mem_we, 0);
        post(32'h9000);
        #1;
        chk(wr_idx == 0, "R3 write index wrapped", 32'(wr_idx), 0);
      end
    join
    chk(rd_idx == 0, "R3 read index wrapped", 32'(rd_idx), 0);

    for (int i = 0; i < 3; i++) post(32'hA000 + 32'(i) * 32'h40);
    for (int i = 0; i < 3; i++) send_pkt(2 + i, 12'(i), 1'(i), 8'(8'hE0 + 8'(i)));

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5/R6 all writes seen", exp_q.size(), 0);
    chk(done_cnt == pkts, "R8 completions per packet", done_cnt, pkts);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule